// File: doc/BRIEF.md
# Control-Register Watchdog with Fixed Prescaler

This block watches for software that has stopped running its normal sequence. A 7-bit down-counter sits in the low bits of an 8-bit control register, and an arming bit sits at the top. A fixed prescaler divides the processor clock and steps the counter down once per prescaler period. Once armed, the watchdog asks for a processor reset when the counter's top bit clears. That happens as the count crosses from 40h to 3Fh. Software avoids the reset by rewriting the control register often enough with a value in the C0h..FFh range.

Software can also force a reset on purpose. Writing the control register with the arming bit set and bit 6 clear does this at once. A halt event that arrives while the watchdog is armed does the same. Every such reset drives an active-low request output for a fixed number of clock cycles. It also returns the control register to its disarmed value and sets a sticky cause flag in a separate status register. That flag stays set through the watchdog's own reset. Only power-on reset or a software write of 0 clears it.

Register access uses a single write strobe, a one-bit address and a read-data bus that is always valid. Address 0 selects the control register and address 1 the status register.

Top module: `wdt_guard`

## Requirements
- R1: When power-on reset is released, the control register reads 7Fh (arming bit 7 = 0, count 7Fh), the status register reads 00h, and `rst_req_n` is high.
- R2: The count in bits 6:0 drops by one every `PRESCALE_DIV` clock cycles. Every control write restarts the prescaler, so the first decrement after a write lands `PRESCALE_DIV` edges after the write edge.
- R3: While armed, the decrement from 40h to 3Fh starts a reset pulse on that same edge. A value t written at edge w therefore expires at edge w + (t−3Fh)·`PRESCALE_DIV`.
- R4: Each reset pulse holds `rst_req_n` low for exactly `PULSE_CYCLES` clock cycles, after which it goes high again.
- R5: Every watchdog-issued reset returns the control register to 7Fh, which leaves the watchdog disarmed.
- R6: Once armed, the arming bit cannot be cleared by software. A write with bit 7 = 0 still loads bits 6:0 but leaves bit 7 at 1.
- R7: A control write that leaves the arming bit at 1 with bit 6 = 0 starts a reset pulse on its own write edge.
- R8: A `halt_evt` pulse starts a reset pulse on its edge while the watchdog is armed. While disarmed it is ignored.
- R9: The status flag (status bit 0) is set when a reset pulse starts and survives that reset. A status write with bit 0 = 0 clears it, a write with bit 0 = 1 leaves it unchanged, and power-on reset clears it.
- R10: While disarmed, the count keeps decrementing through 40h→3Fh with no reset and wraps from 00h to 7Fh.
- R11: Control writes made while a reset pulse is active are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| por_n | input | 1 | Active-low power-on reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | Register select: 0 control, 1 status |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for the selected register (combinational) |
| halt_evt | input | 1 | One-cycle halt event |
| rst_req_n | output | 1 | Active-low reset request pulse |

## Verification
Every result is counted in clock edges from the edge that takes in the stimulus, called edge 0. A register write or a halt event shows on the read bus and on `rst_req_n` right after edge 0. A decrement is due exactly `PRESCALE_DIV` edges after the previous one or after the write. An armed expiry falls at (t−3Fh)·`PRESCALE_DIV` edges, and a pulse ends `PULSE_CYCLES` edges after it starts. The bench drives on the falling edge, steps a whole number of rising edges, and samples one step later. It checks the cycle just before and the cycle at each predicted edge.

// File: rtl/wdt_guard_pkg.sv
package wdt_guard_pkg;
   localparam int unsigned CNT_W   = 7;
   localparam int unsigned REG_W   = CNT_W + 1;
   localparam logic [REG_W-1:0] CR_RESET = 8'h7F;
   localparam logic [CNT_W-1:0] CNT_EXPIRE_FROM = 7'h40;
   localparam logic ADDR_CTRL = 1'b0;
   localparam logic ADDR_STAT = 1'b1;

   typedef enum logic [1:0] {
      CAUSE_NONE   = 2'd0,
      CAUSE_EXPIRE = 2'd1,
      CAUSE_SOFT   = 2'd2,
      CAUSE_HALT   = 2'd3
   } wdt_cause_e;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
   parameter int unsigned DIV = 12288
) (
   input  logic clk,
   input  logic por_n,
   input  logic clr,
   output logic tick
);
   generate
      if (DIV < 1) begin : g_bad_div
         $error("wdt_prescaler: DIV must be at least 1");
      end
      if (DIV == 1) begin : g_pass
         assign tick = 1'b1;
      end else begin : g_count
         localparam int unsigned PW = $clog2(DIV);
         localparam logic [PW-1:0] LAST = PW'(DIV - 1);
         logic [PW-1:0] pre_q;

         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n)            pre_q <= '0;
            else if (clr)          pre_q <= '0;
            else if (pre_q == LAST) pre_q <= '0;
            else                   pre_q <= pre_q + PW'(1);
         end

         assign tick = (pre_q == LAST);

         AST_PRESCALE_RANGE: assert property (@(posedge clk) disable iff (!por_n)
            pre_q <= LAST); // R2
         AST_PRESCALE_RESTART: assert property (@(posedge clk) disable iff (!por_n)
            clr |=> !tick); // R2
      end
   endgenerate
endmodule

// File: rtl/wdt_pulse_gen.sv
module wdt_pulse_gen #(
   parameter int unsigned PULSE_CYCLES = 4
) (
   input  logic clk,
   input  logic por_n,
   input  logic start,
   output logic busy,
   output logic rst_req_n
);
   localparam int unsigned CW = $clog2(PULSE_CYCLES + 1);
   localparam logic [CW-1:0] LOAD = CW'(PULSE_CYCLES);

   logic [CW-1:0] left_q;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)             left_q <= '0;
      else if (start)         left_q <= LOAD;
      else if (left_q != '0)  left_q <= left_q - CW'(1);
   end

   assign busy      = (left_q != '0);
   assign rst_req_n = ~busy;

   AST_NO_RETRIGGER: assert property (@(posedge clk) disable iff (!por_n)
      start |-> !busy); // R11
endmodule

// File: rtl/wdt_ctrl_reg.sv
module wdt_ctrl_reg
   import wdt_guard_pkg::*;
(
   input  logic             clk,
   input  logic             por_n,
   input  logic             hold,
   input  logic             cr_we,
   input  logic [REG_W-1:0] cr_wdata,
   input  logic             tick,
   input  logic             halt_evt,
   output logic [REG_W-1:0] cr_q,
   output wdt_cause_e       cause
);
   logic             armed_q;
   logic [CNT_W-1:0] cnt_q;
   logic             armed_next;

   assign armed_next = armed_q | cr_wdata[REG_W-1];

   always_comb begin
      cause = CAUSE_NONE;
      if (!hold) begin
         if (cr_we && armed_next && !cr_wdata[CNT_W-1])
            cause = CAUSE_SOFT;
         else if (armed_q && halt_evt)
            cause = CAUSE_HALT;
         else if (armed_q && !cr_we && tick && cnt_q == CNT_EXPIRE_FROM)
            cause = CAUSE_EXPIRE;
      end
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         armed_q <= CR_RESET[REG_W-1];
         cnt_q   <= CR_RESET[CNT_W-1:0];
      end else if (hold || cause != CAUSE_NONE) begin
         armed_q <= CR_RESET[REG_W-1];
         cnt_q   <= CR_RESET[CNT_W-1:0];
      end else if (cr_we) begin
         armed_q <= armed_next;
         cnt_q   <= cr_wdata[CNT_W-1:0];
      end else if (tick) begin
         cnt_q   <= cnt_q - CNT_W'(1);
      end
   end

   assign cr_q = {armed_q, cnt_q};

   AST_STICKY_ENABLE: assert property (@(posedge clk) disable iff (!por_n)
      (armed_q && !hold) |=> (armed_q || hold)); // R6
   AST_EXPIRE_FIRES: assert property (@(posedge clk) disable iff (!por_n)
      (armed_q && !hold && !cr_we && tick && cnt_q == CNT_EXPIRE_FROM) |=> hold); // R3
   AST_HALT_FIRES: assert property (@(posedge clk) disable iff (!por_n)
      (armed_q && !hold && halt_evt) |=> hold); // R8
   AST_DISARMED_QUIET: assert property (@(posedge clk) disable iff (!por_n)
      (!armed_q && !hold && !cr_we) |=> !hold); // R10
endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
   import wdt_guard_pkg::*;
#(
   parameter int unsigned PRESCALE_DIV = 12288,
   parameter int unsigned PULSE_CYCLES = 4
) (
   input  logic       clk,
   input  logic       por_n,
   input  logic       wr_en,
   input  logic       addr,
   input  logic [7:0] wr_data,
   output logic [7:0] rd_data,
   input  logic       halt_evt,
   output logic       rst_req_n
);
   generate
      if (PRESCALE_DIV < 1) begin : g_bad_div
         $error("wdt_guard: PRESCALE_DIV must be at least 1");
      end
      if (PULSE_CYCLES < 1) begin : g_bad_pulse
         $error("wdt_guard: PULSE_CYCLES must be at least 1");
      end
   endgenerate

   logic             cr_we;
   logic             tick;
   logic             busy;
   logic             start;
   logic             flag_q;
   logic [REG_W-1:0] cr_q;
   wdt_cause_e       cause;

   assign cr_we = wr_en && (addr == ADDR_CTRL);
   assign start = (cause != CAUSE_NONE);

   wdt_prescaler #(.DIV(PRESCALE_DIV)) u_pre (
      .clk   (clk),
      .por_n (por_n),
      .clr   (cr_we | start | busy),
      .tick  (tick)
   );

   wdt_ctrl_reg u_ctrl (
      .clk      (clk),
      .por_n    (por_n),
      .hold     (busy),
      .cr_we    (cr_we),
      .cr_wdata (wr_data),
      .tick     (tick),
      .halt_evt (halt_evt),
      .cr_q     (cr_q),
      .cause    (cause)
   );

   wdt_pulse_gen #(.PULSE_CYCLES(PULSE_CYCLES)) u_pulse (
      .clk       (clk),
      .por_n     (por_n),
      .start     (start),
      .busy      (busy),
      .rst_req_n (rst_req_n)
   );

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)
         flag_q <= 1'b0;
      else if (start)
         flag_q <= 1'b1;
      else if (wr_en && addr == ADDR_STAT && !wr_data[0])
         flag_q <= 1'b0;
   end

   assign rd_data = (addr == ADDR_CTRL) ? cr_q : {7'b0, flag_q};

   AST_FLAG_ON_RESET: assert property (@(posedge clk) disable iff (!por_n)
      $fell(rst_req_n) |-> flag_q); // R9
   AST_RESET_CLEARS_CR: assert property (@(posedge clk) disable iff (!por_n)
      $fell(rst_req_n) |-> cr_q == CR_RESET); // R5
endmodule

// File: tb/wdt_guard_tb_top.sv
module wdt_guard_tb_top;
   localparam int DIV = 20;
   localparam int PW  = 4;

   logic       clk = 1'b0;
   logic       por_n = 1'b0;
   logic       wr_en = 1'b0;
   logic       addr = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] rd_data;
   logic       halt_evt = 1'b0;
   logic       rst_req_n;

   int total = 0;
   int bad = 0;
   int cyc = 0;
   bit done = 0;

   always #5 clk = ~clk;

   wdt_guard #(.PRESCALE_DIV(DIV), .PULSE_CYCLES(PW)) dut_i (
      .clk(clk), .por_n(por_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
      .rd_data(rd_data), .halt_evt(halt_evt), .rst_req_n(rst_req_n)
   );

   function automatic int expiry_edges(input logic [6:0] t);
      return (int'(t) - 'h3F) * DIV;
   endfunction

   function automatic logic [7:0] cr_after(input logic [7:0] v, input int k);
      return {v[7], 7'(int'(v[6:0]) - k / DIV)};
   endfunction

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic steps(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         @(negedge clk);
      end
   endtask

   task automatic rd(input logic a, output logic [7:0] d);
      addr = a;
      #1;
      d = rd_data;
   endtask

   task automatic wr(input logic a, input logic [7:0] d);
      addr = a; wr_data = d; wr_en = 1'b1;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic halt_pulse();
      halt_evt = 1'b1;
      @(posedge clk);
      @(negedge clk);
      halt_evt = 1'b0;
   endtask

   task automatic do_por();
      por_n = 1'b0;
      steps(2);
      por_n = 1'b1;
      steps(1);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         bad++;
         total++;
         $display("FAIL watchdog act=%0d exp=<150000", cyc);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      void'($urandom(32'd4242));
      @(negedge clk);
      do_por();

      // R1 reset state
      rd(0, d); chk("R1 ctrl", d, 8'h7F);
      rd(1, d); chk("R1 stat", d, 8'h00);
      chk("R1 rst", {7'b0, rst_req_n}, 8'h01);

      // R10 disarmed: pass 40->3F silently, then wrap 00->7F
      wr(0, 8'h41);
      steps(DIV - 1); rd(0, d); chk("R2 before step", d, 8'h41);
      steps(1);       rd(0, d); chk("R2 step", d, 8'h40);
      steps(DIV);     rd(0, d); chk("R10 crossing", d, 8'h3F);
      chk("R10 no reset", {7'b0, rst_req_n}, 8'h01);
      wr(0, 8'h01);
      steps(2 * DIV); rd(0, d); chk("R10 wrap", d, 8'h7F);

      // R8 halt while disarmed ignored
      halt_pulse();
      chk("R8 halt ignored", {7'b0, rst_req_n}, 8'h01);
      rd(0, d); chk("R8 ctrl kept", d, 8'h7F);

      // R6 sticky arm bit
      wr(0, 8'hC8);
      wr(0, 8'h48);
      rd(0, d); chk("R6 sticky", d, 8'hC8);
      chk("R6 no reset", {7'b0, rst_req_n}, 8'h01);

      // R7 soft reset via bit6=0 with bit7 already armed; R4 width; R11
      wr(0, 8'h08);
      chk("R7 immediate", {7'b0, rst_req_n}, 8'h00);
      rd(0, d); chk("R5 ctrl cleared", d, 8'h7F);
      wr(0, 8'hC5);
      steps(PW - 2);
      chk("R4 still low", {7'b0, rst_req_n}, 8'h00);
      steps(1);
      chk("R4 released", {7'b0, rst_req_n}, 8'h01);
      rd(0, d); chk("R11 write ignored", d, 8'h7F);

      // R9 flag behaviour
      rd(1, d); chk("R9 flag set", d, 8'h01);
      wr(1, 8'h01); rd(1, d); chk("R9 write1 keeps", d, 8'h01);
      wr(1, 8'h00); rd(1, d); chk("R9 write0 clears", d, 8'h00);

      // R8 halt while armed
      wr(0, 8'hFF);
      halt_pulse();
      chk("R8 halt reset", {7'b0, rst_req_n}, 8'h00);
      steps(PW);
      rd(1, d); chk("R9 flag after halt", d, 8'h01);
      do_por();
      rd(1, d); chk("R9 por clears", d, 8'h00);

      // R7 from disarmed with 80h
      wr(0, 8'h80);
      chk("R7 soft from idle", {7'b0, rst_req_n}, 8'h00);
      steps(PW);

      // R2/R3 random refresh values with timed expiry
      for (int it = 0; it < 14; it++) begin
         logic [7:0] v;
         int e, k1;
         v  = 8'hC0 | 8'($urandom % 64);
         e  = expiry_edges(v[6:0]);
         k1 = int'($urandom % e);
         if (it % 4 == 1) begin
            wr(0, 8'hC0 | 8'($urandom % 64));
            steps(int'($urandom % DIV));
         end
         wr(0, v);
         steps(k1);
         rd(0, d); chk("R2 count", d, cr_after(v, k1));
         steps(e - 1 - k1);
         chk("R3 not yet", {7'b0, rst_req_n}, 8'h01);
         steps(1);
         chk("R3 expiry", {7'b0, rst_req_n}, 8'h00);
         rd(0, d); chk("R5 disarmed", d, 8'h7F);
         steps(PW);
         chk("R4 end", {7'b0, rst_req_n}, 8'h01);
      end

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule